// File: doc/BRIEF.md
# Block-Companded Audio Sample Rebuilder

This block turns block-companded audio words back into linear 16-bit samples and recodes them for a converter. Each block of samples carries one scale factor. The scale factor is received as three copies, and the block recovers it by a bitwise 2-of-3 vote. The vote result waits in a pending register until the next block begins.

Each sample arrives in one valid cycle. It comes as 11 protected high bits and 3 unprotected low bits, which are joined into a 14-bit two's-complement word. That word is placed at the top of a 21-bit working word. The working word is shifted right by the active scale factor, with the sign bit copied into the vacated positions. The upper 16 bits form the sample. A 2-bit select then picks one of four number formats for the registered output.

Top module: `sf_sample_rebuild`

## Requirements
- R1: When `sf_valid` is high, each bit of the pending scale factor takes the value held by at least two of `sf_copy_a`, `sf_copy_b` and `sf_copy_c` at that bit position.
- R2: A cycle with `blk_start` high uses the pending scale factor for the sample presented in that same cycle. That scale factor then stays in force for every later sample until the next `blk_start`. If `sf_valid` and `blk_start` are high together, the earlier pending value is the one applied.
- R3: Loading a new pending scale factor without `blk_start` does not change the shift applied to the samples that follow it in the current block.
- R4: The sample word is `{smp_hi, smp_lo}`, read as a 14-bit two's-complement value. `smp_hi[10]` is its sign.
- R5: In two's-complement format, `out_sample` equals floor(word × 4 / 2^sf), where sf is the applied scale factor (0 to 7). With sf = 0 this is the word shifted left by two.
- R6: Bits vacated by the shift-back hold the sign of the word. A negative word therefore never yields a non-negative result, and a non-negative word never yields a negative result.
- R7: The `fmt_sel` encodings are: 11 gives two's complement; 10 gives all 16 bits inverted; 01 gives the MSB inverted (offset binary); 00 gives all bits except the MSB inverted (complemented offset binary).
- R8: `out_valid` and `out_sample` update one clock after a cycle with `smp_valid` high. `out_sample` holds its value after any cycle with `smp_valid` low.
- R9: While `rst_n` is low, `out_valid` and `out_sample` are zero and both scale-factor registers are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sf_valid | input | 1 | Three scale-factor copies are present |
| sf_copy_a | input | 3 | First received copy of the scale factor |
| sf_copy_b | input | 3 | Second received copy |
| sf_copy_c | input | 3 | Third received copy |
| blk_start | input | 1 | Marks the first sample of a block |
| smp_valid | input | 1 | A sample is present |
| smp_hi | input | 11 | Corrected upper sample bits |
| smp_lo | input | 3 | Unprotected lower sample bits |
| fmt_sel | input | 2 | Output number format |
| out_valid | output | 1 | Output sample is new this cycle |
| out_sample | output | 16 | Reconstructed, recoded sample |

## Verification
The hardest situation to reach is the handover between scale factors. A fresh pending value must stay invisible until `blk_start`, and must then act on the very sample that carries the strobe. The stimulus loads a new value through deliberately disagreeing copies in the middle of a block. It then checks a sample under the old shift, and then a strobed sample under the new one. Each of the eight scale factors is reached only through voting on mismatched copies. For each one, the bench sweeps a dense stride of the 14-bit word space plus the extreme words, and rotates through all four output formats.

// File: rtl/sf_sample_rebuild.sv
module sf_sample_rebuild #(
  parameter int SF_W  = 3,
  parameter int HI_W  = 11,
  parameter int LO_W  = 3,
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sf_valid,
  input  logic [SF_W-1:0]  sf_copy_a,
  input  logic [SF_W-1:0]  sf_copy_b,
  input  logic [SF_W-1:0]  sf_copy_c,
  input  logic             blk_start,
  input  logic             smp_valid,
  input  logic [HI_W-1:0]  smp_hi,
  input  logic [LO_W-1:0]  smp_lo,
  input  logic [1:0]       fmt_sel,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_sample
);
  localparam int SMP_W  = HI_W + LO_W;
  localparam int WORK_W = SMP_W + (1 << SF_W) - 1;

  logic [SF_W-1:0] sf_vote, sf_pend, sf_cur, sf_use;
  logic signed [WORK_W-1:0] work, shifted;
  logic [OUT_W-1:0] twos, flip;

  assign sf_vote = (sf_copy_a & sf_copy_b) | (sf_copy_a & sf_copy_c) | (sf_copy_b & sf_copy_c);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sf_pend <= '0;
      sf_cur  <= '0;
    end else begin
      if (sf_valid)  sf_pend <= sf_vote;
      if (blk_start) sf_cur  <= sf_pend;
    end
  end

  assign sf_use  = blk_start ? sf_pend : sf_cur;
  assign work    = {smp_hi, smp_lo, {(WORK_W-SMP_W){1'b0}}};
  assign shifted = work >>> sf_use;
  assign twos    = shifted[WORK_W-1 -: OUT_W];
  assign flip    = {fmt_sel[1] ^ fmt_sel[0], {(OUT_W-1){~fmt_sel[0]}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= smp_valid;
      if (smp_valid) out_sample <= twos ^ flip;
    end
  end
endmodule

// File: rtl/sf_sample_rebuild_chk.sv
module sf_sample_rebuild_chk #(
  parameter int HI_W  = 11,
  parameter int LO_W  = 3,
  parameter int OUT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_valid,
  input logic [HI_W-1:0]  smp_hi,
  input logic [LO_W-1:0]  smp_lo,
  input logic [1:0]       fmt_sel,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_sample
);
  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(smp_valid));

  assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(smp_valid) |-> $stable(out_sample));

  assert_sign_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(smp_valid) && $past(fmt_sel) == 2'b11) |-> out_sample[OUT_W-1] == $past(smp_hi[HI_W-1]));

  assert_offset_msb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(smp_valid) && $past(fmt_sel) == 2'b01) |-> out_sample[OUT_W-1] != $past(smp_hi[HI_W-1]));

  assert_zero_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(smp_valid) && $past(fmt_sel) == 2'b11 && $past(smp_hi) == '0 && $past(smp_lo) == '0)
      |-> out_sample == '0);

  assert_reset_clear_R9: assert property (@(posedge clk)
    !$past(rst_n) |-> (!out_valid && out_sample == '0));
endmodule

bind sf_sample_rebuild sf_sample_rebuild_chk #(.HI_W(HI_W), .LO_W(LO_W), .OUT_W(OUT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_hi(smp_hi), .smp_lo(smp_lo),
  .fmt_sel(fmt_sel), .out_valid(out_valid), .out_sample(out_sample));

// File: tb/test_sf_sample_rebuild.sv
`timescale 1ns/100ps
module test_sf_sample_rebuild;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sf_valid = 0, blk_start = 0, smp_valid = 0;
  logic [2:0] sf_copy_a = 0, sf_copy_b = 0, sf_copy_c = 0;
  logic [10:0] smp_hi = 0;
  logic [2:0] smp_lo = 0;
  logic [1:0] fmt_sel = 2'b11;
  logic out_valid;
  logic [15:0] out_sample;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sf_sample_rebuild i_sf_sample_rebuild (.*);

  function automatic logic [15:0] expect_val(input int w14, input int sf, input logic [1:0] f);
    int v, r;
    logic [15:0] t;
    v = (w14 >= 8192) ? w14 - 16384 : w14;
    r = (v * 4) >>> sf;
    t = r[15:0];
    case (f)
      2'b11: return t;
      2'b10: return ~t;
      2'b01: return {~t[15], t[14:0]};
      default: return {t[15], ~t[14:0]};
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_sf(input int s, input int m, input logic bs);
    @(negedge clk);
    sf_valid = 1; blk_start = bs; smp_valid = 0;
    sf_copy_a = s[2:0]; sf_copy_b = s[2:0] ^ m[2:0]; sf_copy_c = s[2:0] ^ ~m[2:0];
    @(negedge clk);
    sf_valid = 0; blk_start = 0;
  endtask

  task automatic put(input int w, input logic [1:0] f, input logic bs, input int sf, input string req);
    @(negedge clk);
    smp_valid = 1; blk_start = bs; fmt_sel = f;
    {smp_hi, smp_lo} = w[13:0];
    @(posedge clk); #1;
    check(req, out_sample, expect_val(w, sf, f));
    total++;
    if (out_valid !== 1'b1) begin bad++; $display("FAIL R8 out_valid actual=%b expected=1", out_valid); end
    @(negedge clk);
    smp_valid = 0; blk_start = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset sample", out_sample, 16'h0);
    check("R9 reset valid", {15'h0, out_valid}, 16'h0);
    @(negedge clk); rst_n = 1;
    // R9: reset pending scale is zero
    put(16'h1234 & 14'h3fff, 2'b11, 1'b1, 0, "R9 reset scale");
    // R8 hold
    @(negedge clk); smp_hi = 11'h7ff; smp_lo = 3'h5;
    @(posedge clk); #1;
    check("R8 hold", out_sample, expect_val(16'h1234 & 14'h3fff, 0, 2'b11));
    check("R8 idle valid", {15'h0, out_valid}, 16'h0);
    for (int s = 0; s < 8; s++) begin
      load_sf(s, (s * 3 + 1) & 7, 1'b0);           // R1 vote over disagreeing copies
      put(14'h2001, 2'b11, 1'b1, s, "R2 first sample new scale");
      for (int w = 0; w < 16384; w += 7)
        put(w, w[1:0], 1'b0, s, "R5 R7 sweep");
      put(14'h1fff, 2'b11, 1'b0, s, "R5 max positive");
      put(14'h2000, 2'b11, 1'b0, s, "R6 min negative");
      put(14'h3fff, 2'b11, 1'b0, s, "R6 minus one fill");
      put(14'h0000, 2'b00, 1'b0, s, "R7 zero compl offset");
      put(14'h2000, 2'b10, 1'b0, s, "R7 compl twos");
      put(14'h1fff, 2'b01, 1'b0, s, "R7 offset");
      // R3: new pending mid-block does not act yet
      load_sf((s + 3) & 7, 5, 1'b0);
      put(14'h2abc, 2'b11, 1'b0, s, "R3 old scale kept");
      put(14'h155a, 2'b11, 1'b0, s, "R4 merge bits");
    end
    // R2: simultaneous load and block start applies earlier pending
    load_sf(2, 6, 1'b0);
    @(negedge clk);
    sf_valid = 1; sf_copy_a = 3'd7; sf_copy_b = 3'd7; sf_copy_c = 3'd7;
    smp_valid = 1; blk_start = 1; fmt_sel = 2'b11; {smp_hi, smp_lo} = 14'h3000;
    @(posedge clk); #1;
    check("R2 same-cycle load", out_sample, expect_val(14'h3000, 2, 2'b11));
    @(negedge clk); sf_valid = 0; blk_start = 0; smp_valid = 0;
    put(14'h3000, 2'b11, 1'b0, 2, "R2 block keeps scale");
    put(14'h3000, 2'b11, 1'b1, 7, "R1 unanimous vote");
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule